// File: doc/BRIEF.md
# Write Permission and Status Controller for a Serial Memory

This block decides whether the write commands of a small serial nonvolatile memory may proceed. It holds three things: the volatile write-enable flag, a two-bit array-protection level, and the busy flag of the self-timed internal write. The command decoder in front of it sends single-cycle events:
- an enable opcode fully received;
- a further serial bit clocked in while still selected;
- chip deselect;
- a disable opcode;
- a commit request for an array page or for the status register.

The block answers each commit with a registered grant or deny pulse and presents the status byte that the decoder shifts out on a status read.

Write permission is granted only when all of these hold:
- a hardware protect pin is high;
- the enable flag is set;
- no internal write is running;
- for array writes, the target page lies outside the protected partition.

A granted commit starts an internal write of `WR_CYCLES` clock cycles, which stands in for the programming time. Nothing aborts that write. When it ends, the enable flag is cleared. A new protection level written through a status commit becomes visible only at that moment.

The array has `2**ADDR_W` bytes in pages of `2**PAGE_W` bytes. The protection level selects none, the top quarter, the top half, or all of the array.

Top module: `wrperm_ctrl`

## Requirements
- R1: The status byte is bit 0 = busy, bit 1 = write-enable flag, bits 3:2 = protection level, bits 7:4 = 0. After reset it reads 0x00 and `busy_o`, `grant_o` and `deny_o` are 0.
- R2: An enable opcode followed by a deselect sets the enable flag. A disable opcode clears it. Neither depends on the protection level.
- R3: If another serial bit arrives between the enable opcode and the deselect, the enable flag stays clear.
- R4: Whenever `wr_pin_i` is 0, the enable flag is cleared in the next cycle, an enable sequence completing in that cycle has no effect, and every commit is denied.
- R5: A commit while the enable flag is 0 is denied and leaves the status byte unchanged.
- R6: An array commit for page p with protection level L is denied when the page's quarter index q = p / (pages/4) satisfies q >= 4 - n, where n = 0, 1, 2, 4 for L = 00, 01, 10, 11. A denied commit leaves the enable flag set and `busy_o` at 0.
- R7: A status commit with the enable flag set and the pin high is granted at every protection level.
- R8: A granted commit raises `busy_o` on the same edge as `grant_o` and keeps it high for exactly `WR_CYCLES` cycles. When it falls, the enable flag is cleared. After a status commit, bits 3:2 then show `sts_bp_i` as sampled with the commit, and not earlier.
- R9: While busy, pin activity, deselects, enable and disable opcodes and commits do not shorten the write. Every commit is denied, including one in the last busy cycle. The status byte stays readable with bit 0 = 1.
- R10: Every commit request cycle is answered one cycle later by exactly one of `grant_o` and `deny_o`. An array commit and a status commit in the same cycle are denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_pin_i | input | 1 | Hardware protect pin, 1 allows writes |
| op_wren_i | input | 1 | Enable opcode fully received (pulse) |
| bit_more_i | input | 1 | Another serial bit clocked in while selected (pulse) |
| desel_i | input | 1 | Chip select deasserted (pulse) |
| op_wrdi_i | input | 1 | Disable opcode received (pulse) |
| commit_arr_i | input | 1 | Array write commit request (pulse) |
| commit_sts_i | input | 1 | Status write commit request (pulse) |
| commit_page_i | input | ADDR_W-PAGE_W | Page index of the array commit |
| sts_bp_i | input | 2 | New protection level carried by a status commit |
| grant_o | output | 1 | Commit accepted (pulse) |
| deny_o | output | 1 | Commit refused (pulse) |
| busy_o | output | 1 | Internal write running |
| status_o | output | 8 | Status byte |

## Verification
Two functions of the block can fall into the same cycle.

The first pair is the end of the timed write and a new commit. The bench counts the busy cycles of a running write and issues a commit so that it is sampled on the very edge that ends the write. Judged correct: `deny_o` pulses, `busy_o` drops on schedule, and the enable flag is cleared.

The second pair is the pin dropping and an enable sequence completing with its deselect. The bench drives both in one cycle. Judged correct: the status byte afterwards shows the enable flag at 0.

A near-exhaustive sweep over all four protection levels and all 32 pages compares grant and deny with a quarter-threshold formula computed in the bench.

// File: rtl/wrperm_pkg.sv
package wrperm_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'b00,
        LVL_QTR  = 2'b01,
        LVL_HALF = 2'b10,
        LVL_ALL  = 2'b11
    } prot_lvl_e;

    typedef struct packed {
        logic grant;
        logic deny;
    } verdict_t;

    // number of locked quarters, counted from the top of the array
    function automatic int unsigned locked_quarters(prot_lvl_e lvl);
        case (lvl)
            LVL_NONE: return 0;
            LVL_QTR:  return 1;
            LVL_HALF: return 2;
            default:  return 4;
        endcase
    endfunction

    function automatic logic [7:0] pack_status(prot_lvl_e lvl, logic wel, logic busy);
        return {4'b0000, lvl, wel, busy};
    endfunction

endpackage

// File: rtl/wrperm_timer.sv
module wrperm_timer #(
    parameter int unsigned WR_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    assign done = busy_q && (cnt_q == '0);
    assign busy = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_LOAD;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wrperm_wel.sv
module wrperm_wel (
    input  logic clk,
    input  logic rst,
    input  logic pin_ok,
    input  logic busy,
    input  logic done,
    input  logic op_wren,
    input  logic bit_more,
    input  logic desel,
    input  logic op_wrdi,
    output logic wel
);
    logic arm_q;
    logic wel_q;

    assign wel = wel_q;

    // an enable opcode is armed until the next bit or the deselect
    always_ff @(posedge clk) begin
        if (rst)                     arm_q <= 1'b0;
        else if (op_wren && !busy)   arm_q <= 1'b1;
        else if (bit_more || desel)  arm_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                  wel_q <= 1'b0;
        else if (!pin_ok)         wel_q <= 1'b0;
        else if (done)            wel_q <= 1'b0;
        else if (busy)            wel_q <= wel_q;
        else if (op_wrdi)         wel_q <= 1'b0;
        else if (desel && arm_q)  wel_q <= 1'b1;
    end
endmodule

// File: rtl/wrperm_gate.sv
module wrperm_gate
    import wrperm_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned PAGE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_arr,
    input  logic                     req_sts,
    input  logic [ADDR_W-PAGE_W-1:0] page,
    input  logic [1:0]               new_lvl,
    input  logic                     wel,
    input  logic                     pin_ok,
    input  logic                     busy,
    input  logic                     done,
    output logic                     start,
    output verdict_t                 verdict,
    output prot_lvl_e                lvl
);
    localparam int unsigned PIDX_W = ADDR_W - PAGE_W;
    localparam int unsigned NPAGES = 1 << PIDX_W;

    prot_lvl_e lvl_q, lvl_new_q;
    logic      lvl_pend_q;
    verdict_t  verdict_q;
    logic      locked, any_req, ok;

    always_comb begin
        // page is locked when 4*page >= NPAGES*(4 - locked quarters)
        locked  = (int'(page) * 4) >= (int'(NPAGES) * (4 - int'(locked_quarters(lvl_q))));
        any_req = req_arr || req_sts;
        ok      = (req_arr ^ req_sts) && !busy && pin_ok && wel && (req_sts || !locked);
        start   = any_req && ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q  <= '0;
            lvl_q      <= LVL_NONE;
            lvl_new_q  <= LVL_NONE;
            lvl_pend_q <= 1'b0;
        end else begin
            verdict_q.grant <= any_req && ok;
            verdict_q.deny  <= any_req && !ok;
            if (start && req_sts) begin
                lvl_pend_q <= 1'b1;
                lvl_new_q  <= prot_lvl_e'(new_lvl);
            end else if (done && lvl_pend_q) begin
                lvl_pend_q <= 1'b0;
                lvl_q      <= lvl_new_q;
            end
        end
    end

    assign verdict = verdict_q;
    assign lvl     = lvl_q;
endmodule

// File: rtl/wrperm_ctrl.sv
module wrperm_ctrl
    import wrperm_pkg::*;
#(
    parameter int unsigned ADDR_W    = 9,
    parameter int unsigned PAGE_W    = 4,
    parameter int unsigned WR_CYCLES = 1000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_pin_i,
    input  logic                     op_wren_i,
    input  logic                     bit_more_i,
    input  logic                     desel_i,
    input  logic                     op_wrdi_i,
    input  logic                     commit_arr_i,
    input  logic                     commit_sts_i,
    input  logic [ADDR_W-PAGE_W-1:0] commit_page_i,
    input  logic [1:0]               sts_bp_i,
    output logic                     grant_o,
    output logic                     deny_o,
    output logic                     busy_o,
    output logic [7:0]               status_o
);
    logic      busy, done, start, wel;
    verdict_t  verdict;
    prot_lvl_e lvl;

    wrperm_timer #(.WR_CYCLES(WR_CYCLES)) timer_i (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done)
    );

    wrperm_wel wel_i (
        .clk(clk), .rst(rst), .pin_ok(wr_pin_i), .busy(busy), .done(done),
        .op_wren(op_wren_i), .bit_more(bit_more_i), .desel(desel_i),
        .op_wrdi(op_wrdi_i), .wel(wel)
    );

    wrperm_gate #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) gate_i (
        .clk(clk), .rst(rst), .req_arr(commit_arr_i), .req_sts(commit_sts_i),
        .page(commit_page_i), .new_lvl(sts_bp_i), .wel(wel), .pin_ok(wr_pin_i),
        .busy(busy), .done(done), .start(start), .verdict(verdict), .lvl(lvl)
    );

    assign grant_o  = verdict.grant;
    assign deny_o   = verdict.deny;
    assign busy_o   = busy;
    assign status_o = pack_status(lvl, wel, busy);
endmodule

// File: rtl/wrperm_ctrl_chk.sv
module wrperm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_pin_i,
    input logic       commit_arr_i,
    input logic       commit_sts_i,
    input logic       grant_o,
    input logic       deny_o,
    input logic       busy_o,
    input logic [7:0] status_o
);
    p_one_verdict_r10: assert property (@(posedge clk) disable iff (rst)
        (commit_arr_i || commit_sts_i) |=> (grant_o ^ deny_o));

    p_verdict_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(grant_o && deny_o));

    p_dual_denied_r10: assert property (@(posedge clk) disable iff (rst)
        (commit_arr_i && commit_sts_i) |=> deny_o);

    p_grant_busy_r8: assert property (@(posedge clk) disable iff (rst)
        grant_o |-> busy_o);

    p_lvl_moves_at_end_r8: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> $stable(status_o[3:2]));

    p_pin_clears_wel_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_pin_i |=> !status_o[1]);

    p_pin_denies_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr_pin_i && (commit_arr_i || commit_sts_i)) |=> deny_o);

    p_busy_denies_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && (commit_arr_i || commit_sts_i)) |=> deny_o);

    p_status_busy_bit_r1: assert property (@(posedge clk) disable iff (rst)
        status_o[0] == busy_o && status_o[7:4] == 4'h0);
endmodule

bind wrperm_ctrl wrperm_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .wr_pin_i(wr_pin_i), .commit_arr_i(commit_arr_i),
    .commit_sts_i(commit_sts_i), .grant_o(grant_o), .deny_o(deny_o),
    .busy_o(busy_o), .status_o(status_o)
);

// File: tb/wrperm_ctrl_tb.sv
module wrperm_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 9;
    localparam int PAGE_W = 4;
    localparam int WR     = 8;
    localparam int NPG    = 1 << (ADDR_W - PAGE_W);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_pin_i = 1'b1, op_wren_i = 1'b0, bit_more_i = 1'b0, desel_i = 1'b0;
    logic op_wrdi_i = 1'b0, commit_arr_i = 1'b0, commit_sts_i = 1'b0;
    logic [ADDR_W-PAGE_W-1:0] commit_page_i = '0;
    logic [1:0] sts_bp_i = 2'b00;
    logic grant_o, deny_o, busy_o;
    logic [7:0] status_o;

    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wrperm_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR)) dut_i (
        .clk(clk), .rst(rst), .wr_pin_i(wr_pin_i), .op_wren_i(op_wren_i),
        .bit_more_i(bit_more_i), .desel_i(desel_i), .op_wrdi_i(op_wrdi_i),
        .commit_arr_i(commit_arr_i), .commit_sts_i(commit_sts_i),
        .commit_page_i(commit_page_i), .sts_bp_i(sts_bp_i),
        .grant_o(grant_o), .deny_o(deny_o), .busy_o(busy_o), .status_o(status_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wren_seq();
        op_wren_i = 1'b1; step(); op_wren_i = 1'b0;
        desel_i = 1'b1;   step(); desel_i = 1'b0;
    endtask

    task automatic wrdi();
        op_wrdi_i = 1'b1; step(); op_wrdi_i = 1'b0;
    endtask

    task automatic commit(input bit arr, input bit sts, input int page, input int bp);
        commit_arr_i = arr; commit_sts_i = sts;
        commit_page_i = (ADDR_W-PAGE_W)'(page); sts_bp_i = 2'(bp);
        step();
        commit_arr_i = 1'b0; commit_sts_i = 1'b0;
    endtask

    // counts busy cycles, first one already visible on entry
    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o && n < 4*WR) begin n++; step(); end
    endtask

    task automatic set_level(input int bp);
        int n;
        wren_seq();
        commit(1'b0, 1'b1, 0, bp);
        chk("R7 status commit granted", int'(grant_o), 1);
        chk("R8 level held during write", int'(status_o), 8'h03 | (int'(status_o[3:2]) << 2));
        wait_idle(n);
        chk("R8 busy length", n, WR);
        chk("R8 level and cleared flag after write", int'(status_o), bp << 2);
    endtask

    initial begin
        int n;
        bit saw_deny;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1 reset status", int'(status_o), 0);
        chk("R1 reset busy", int'(busy_o), 0);
        chk("R1 reset verdict", int'({grant_o, deny_o}), 0);

        // R2 enable / disable
        wren_seq();
        chk("R2 enable sets flag", int'(status_o), 8'h02);
        wrdi();
        chk("R2 disable clears flag", int'(status_o), 8'h00);

        // R3 extra bit before deselect
        op_wren_i = 1'b1; step(); op_wren_i = 1'b0;
        bit_more_i = 1'b1; step(); bit_more_i = 1'b0;
        desel_i = 1'b1; step(); desel_i = 1'b0;
        chk("R3 broken enable leaves flag clear", int'(status_o), 8'h00);

        // R4 pin low
        wren_seq();
        wr_pin_i = 1'b0; step();
        chk("R4 pin low clears flag", int'(status_o[1]), 0);
        wren_seq();
        chk("R4 enable ignored while pin low", int'(status_o[1]), 0);
        commit(1'b1, 1'b0, 0, 0);
        chk("R4 commit denied while pin low", int'(deny_o), 1);
        wr_pin_i = 1'b1; step();
        // concurrent: pin drop in the deselect cycle of an enable
        op_wren_i = 1'b1; step(); op_wren_i = 1'b0;
        desel_i = 1'b1; wr_pin_i = 1'b0; step(); desel_i = 1'b0; wr_pin_i = 1'b1;
        step();
        chk("R4 pin drop with deselect keeps flag clear", int'(status_o[1]), 0);

        // R5 commit without flag
        commit(1'b1, 1'b0, 3, 0);
        chk("R5 commit without flag denied", int'(deny_o), 1);
        chk("R5 status unchanged", int'(status_o), 0);

        // R10 dual request
        wren_seq();
        commit(1'b1, 1'b1, 0, 1);
        chk("R10 dual commit denied", int'({grant_o, deny_o}), 1);
        chk("R10 dual commit leaves idle", int'(status_o), 8'h02);
        wrdi();

        // R6 / R7 sweep over levels and pages
        for (int bp = 0; bp < 4; bp++) begin
            set_level(bp);
            for (int p = 0; p < NPG; p++) begin
                int nl, q;
                bit lk;
                nl = (bp == 3) ? 4 : bp;
                q  = p / (NPG / 4);
                lk = (q >= 4 - nl);
                wren_seq();
                commit(1'b1, 1'b0, p, 0);
                chk($sformatf("R6 grant lvl=%0d page=%0d", bp, p), int'(grant_o), lk ? 0 : 1);
                if (lk) begin
                    chk("R6 denied keeps flag, idle", int'(status_o), (bp << 2) | 2);
                    wrdi();
                end else begin
                    wait_idle(n);
                    chk("R8 array write length", n, WR);
                    chk("R8 flag cleared after write", int'(status_o), bp << 2);
                end
            end
        end
        set_level(0);

        // R9 disturbances during a write
        wren_seq();
        commit(1'b1, 1'b0, 1, 0);
        chk("R9 write granted", int'(grant_o), 1);
        n = 1; saw_deny = 1'b0;
        while (busy_o && n < 4*WR) begin
            if (n == 2) wr_pin_i = 1'b0;
            if (n == 3) begin wr_pin_i = 1'b1; desel_i = 1'b1; end
            if (n == 4) op_wrdi_i = 1'b1;
            if (n == 5) op_wren_i = 1'b1;
            if (n == 6) commit_sts_i = 1'b1;
            if (n == 7) chk("R9 status readable busy", int'(status_o[0]), 1);
            step();
            {wr_pin_i, desel_i, op_wrdi_i, op_wren_i, commit_sts_i} = 5'b10000;
            if (deny_o) saw_deny = 1'b1;
            n++;
        end
        chk("R9 write not shortened", n - 1, WR);
        chk("R9 commit during write denied", int'(saw_deny), 1);

        // R9 commit landing in the last busy cycle
        wren_seq();
        commit(1'b1, 1'b0, 2, 0);
        for (int j = 1; j < WR; j++) step();
        chk("R9 still busy in last cycle", int'(busy_o), 1);
        commit(1'b1, 1'b0, 2, 0);
        chk("R9 last-cycle commit denied", int'({grant_o, deny_o}), 1);
        chk("R9 write ended on time", int'(busy_o), 0);
        chk("R8 flag cleared at end", int'(status_o), 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule